// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Peripheral Override Pairs

This block is an eight-pin general-purpose I/O port. Each pin has a direction bit and an output bit, both written over a small address/data/write-strobe bus, and a read value that passes through a two-flop synchronizer. From these bits the block drives three pad controls for each pin: output enable, output value and pull-up enable. A single port-wide input switches off every pull-up that comes from the register bits. A sleep input shuts off the digital input buffer.

A peripheral can take over four controls on any pin. Each control has its own enable/value pair: pull-up, output driver enable, driven value and digital input enable. When an enable bit is high, the matching value bit replaces the register-derived control for that pin. The gated pad input is also made available to peripherals directly, before the synchronizer. A peripheral that uses this tap must synchronize it itself.

The bus has four addresses. Address 0 holds the direction bits. Address 1 holds the output bits. Address 2 reads the synchronized pins, and a write to it toggles output bits. Address 3 is reserved.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset, the direction and output bits are 0. With no override active, every pin then has its output enable and pull-up off, and reads at addresses 0 and 1 return 0.
- R2: With a pin's pull-up override enable low, its pull-up is on only when its direction bit is 0, its output bit is 1 and the port-wide pull-up disable is 0.
- R3: With a pin's pull-up override enable high, its pull-up equals the pull-up override value, whatever the direction bit, output bit and port-wide disable are.
- R4: A pin's output enable equals its direction override value when the direction override enable is high. Otherwise it equals its direction bit.
- R5: When a pin's output enable is high and its value override enable is high, the driven value is the value override value. In every other case the driven value is the output bit.
- R6: A pin's digital input enable equals its input override value when the input override enable is high. Otherwise it is 1 when the sleep input is 0 and 0 when the sleep input is 1. A disabled input reads as 0.
- R7: The peripheral input tap equals the gated pad input in the same cycle, with no register in the path.
- R8: A change of the gated pad input appears in the read data at address 2 after exactly two rising clock edges.
- R9: A write to address 0 loads the direction bits and a write to address 1 loads the output bits. A read at the same address returns the stored value on the next cycle.
- R10: A write to address 2 inverts every output bit whose write-data bit is 1 and leaves the other output bits unchanged.
- R11: A write to address 3 changes no register, and a read at address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address: 0 direction, 1 output, 2 pin read/toggle, 3 reserved |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address (combinational) |
| pull_dis | input | 1 | Port-wide disable of register-derived pull-ups |
| sleep_mode | input | 1 | Sleep indication; disables non-overridden digital inputs |
| ovr_pu_en | input | 8 | Per-pin pull-up override enable |
| ovr_pu_val | input | 8 | Per-pin pull-up override value |
| ovr_dir_en | input | 8 | Per-pin output-enable override enable |
| ovr_dir_val | input | 8 | Per-pin output-enable override value |
| ovr_pv_en | input | 8 | Per-pin driven-value override enable |
| ovr_pv_val | input | 8 | Per-pin driven-value override value |
| ovr_die_en | input | 8 | Per-pin digital-input-enable override enable |
| ovr_die_val | input | 8 | Per-pin digital-input-enable override value |
| pad_in | input | 8 | Input buffer levels from the pads |
| pad_oe | output | 8 | Per-pin output driver enable |
| pad_out | output | 8 | Per-pin driven value |
| pad_pu | output | 8 | Per-pin pull-up enable |
| periph_din | output | 8 | Gated, unsynchronized pad input for peripherals |

## Verification
The bench applies mixed override masks, in which some pins of a byte are overridden and the rest are not. A design that applied one enable to the whole port, or picked the wrong half of a mux, then shows wrong bits in a single nibble. Several cases need an exact pattern to catch an error:
- The pull-up must be on only for the 0/1/0 combination. A design that also raised it when the direction bit was set, or that ignored the port-wide disable, fails on a direction/output pattern.
- A value override must be ignored on pins whose driver is off. The bench sets value-override enables on such pins to expose a design that skips the output-enable qualifier.
- Sleep and the input override are exercised together, so a design that lets sleep win over an active override reads zeros.
- Synchronizer latency is checked one edge at a time, which catches one stage too few or too many.
- The toggle path is checked for both a one and a zero in the write data.
- The reserved address is written to show it touches nothing.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

    localparam int unsigned PORT_ADDR_W = 2;

    typedef enum logic [PORT_ADDR_W-1:0] {
        ADR_DIR = 2'd0,
        ADR_OUT = 2'd1,
        ADR_PIN = 2'd2,
        ADR_RSV = 2'd3
    } port_addr_e;

endpackage

// File: rtl/gpio_ovr_lane.sv
module gpio_ovr_lane (
    input  logic dir_bit,
    input  logic out_bit,
    input  logic pull_dis,
    input  logic sleep_mode,
    input  logic pu_en,
    input  logic pu_val,
    input  logic dir_en,
    input  logic dir_val,
    input  logic pv_en,
    input  logic pv_val,
    input  logic die_en,
    input  logic die_val,
    input  logic pad_in,
    output logic pad_oe,
    output logic pad_out,
    output logic pad_pu,
    output logic din
);

    logic oe_int;
    logic in_enable;

    always_comb begin
        // pull-up: override pair wins, else only the input/high/not-disabled case
        if (pu_en) begin
            pad_pu = pu_val;
        end else begin
            pad_pu = !dir_bit && out_bit && !pull_dis;
        end

        oe_int = dir_en ? dir_val : dir_bit;
        pad_oe = oe_int;

        // value override only matters while the driver is on
        if (oe_int && pv_en) begin
            pad_out = pv_val;
        end else begin
            pad_out = out_bit;
        end

        in_enable = die_en ? die_val : !sleep_mode;
        din       = pad_in && in_enable;
    end

endmodule

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        state_d.chain[0] = async_in;
        for (int unsigned s = 1; s < STAGES; s++) begin
            state_d.chain[s] = state_q.chain[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sync_out = state_q.chain[LAST];

endmodule

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
    import gpio_ovr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_we,
    input  logic [PORT_ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]       bus_wdata,
    output logic [WIDTH-1:0]       dir_bits,
    output logic [WIDTH-1:0]       out_bits
);

    typedef struct packed {
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] out;
    } reg_state_t;

    reg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (bus_we) begin
            unique case (port_addr_e'(bus_addr))
                ADR_DIR: state_d.dir = bus_wdata;
                ADR_OUT: state_d.out = bus_wdata;
                ADR_PIN: state_d.out = state_q.out ^ bus_wdata;
                ADR_RSV: state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign dir_bits = state_q.dir;
    assign out_bits = state_q.out;

endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
    import gpio_ovr_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_we,
    input  logic [PORT_ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]       bus_wdata,
    output logic [WIDTH-1:0]       bus_rdata,
    input  logic                   pull_dis,
    input  logic                   sleep_mode,
    input  logic [WIDTH-1:0]       ovr_pu_en,
    input  logic [WIDTH-1:0]       ovr_pu_val,
    input  logic [WIDTH-1:0]       ovr_dir_en,
    input  logic [WIDTH-1:0]       ovr_dir_val,
    input  logic [WIDTH-1:0]       ovr_pv_en,
    input  logic [WIDTH-1:0]       ovr_pv_val,
    input  logic [WIDTH-1:0]       ovr_die_en,
    input  logic [WIDTH-1:0]       ovr_die_val,
    input  logic [WIDTH-1:0]       pad_in,
    output logic [WIDTH-1:0]       pad_oe,
    output logic [WIDTH-1:0]       pad_out,
    output logic [WIDTH-1:0]       pad_pu,
    output logic [WIDTH-1:0]       periph_din
);

    logic [WIDTH-1:0] dir_reg;
    logic [WIDTH-1:0] out_reg;
    logic [WIDTH-1:0] pin_sync;

    gpio_ovr_regs #(.WIDTH(WIDTH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .dir_bits  (dir_reg),
        .out_bits  (out_reg)
    );

    for (genvar p = 0; p < WIDTH; p++) begin : g_lane
        gpio_ovr_lane u_lane (
            .dir_bit    (dir_reg[p]),
            .out_bit    (out_reg[p]),
            .pull_dis   (pull_dis),
            .sleep_mode (sleep_mode),
            .pu_en      (ovr_pu_en[p]),
            .pu_val     (ovr_pu_val[p]),
            .dir_en     (ovr_dir_en[p]),
            .dir_val    (ovr_dir_val[p]),
            .pv_en      (ovr_pv_en[p]),
            .pv_val     (ovr_pv_val[p]),
            .die_en     (ovr_die_en[p]),
            .die_val    (ovr_die_val[p]),
            .pad_in     (pad_in[p]),
            .pad_oe     (pad_oe[p]),
            .pad_out    (pad_out[p]),
            .pad_pu     (pad_pu[p]),
            .din        (periph_din[p])
        );
    end

    gpio_ovr_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (periph_din),
        .sync_out (pin_sync)
    );

    always_comb begin
        unique case (port_addr_e'(bus_addr))
            ADR_DIR: bus_rdata = dir_reg;
            ADR_OUT: bus_rdata = out_reg;
            ADR_PIN: bus_rdata = pin_sync;
            ADR_RSV: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_ovr_port_chk.sv
module gpio_ovr_port_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic [1:0]       bus_addr,
    input logic [WIDTH-1:0] bus_wdata,
    input logic             pull_dis,
    input logic             sleep_mode,
    input logic [WIDTH-1:0] ovr_pu_en,
    input logic [WIDTH-1:0] ovr_pu_val,
    input logic [WIDTH-1:0] ovr_dir_en,
    input logic [WIDTH-1:0] ovr_dir_val,
    input logic [WIDTH-1:0] ovr_pv_en,
    input logic [WIDTH-1:0] ovr_pv_val,
    input logic [WIDTH-1:0] ovr_die_en,
    input logic [WIDTH-1:0] pad_oe,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] pad_pu,
    input logic [WIDTH-1:0] periph_din,
    input logic [WIDTH-1:0] dir_reg,
    input logic [WIDTH-1:0] out_reg,
    input logic [WIDTH-1:0] pin_sync
);

    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // R2: no register-derived pull-up while the port-wide disable is high
    a_r2_pull_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        pull_dis |-> ((pad_pu & ~ovr_pu_en) == '0));

    // R2: no register-derived pull-up on a pin the registers drive
    a_r2_no_pull_when_driving: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & ~ovr_pu_en) & (pad_oe & ~ovr_dir_en)) == '0);

    a_r3_pull_override: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu ^ ovr_pu_val) & ovr_pu_en) == '0);

    a_r4_dir_override: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe ^ ovr_dir_val) & ovr_dir_en) == '0);

    a_r5_value_override: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out ^ ovr_pv_val) & pad_oe & ovr_pv_en) == '0);

    a_r6_sleep_gates_input: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_mode |-> ((periph_din & ~ovr_die_en) == '0));

    a_r8_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (pin_sync == $past(periph_din, 2)));

    a_r9_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && bus_we && bus_addr == 2'd0) |-> (dir_reg == $past(bus_wdata)));

    a_r9_out_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && bus_we && bus_addr == 2'd1) |-> (out_reg == $past(bus_wdata)));

    a_r10_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && bus_we && bus_addr == 2'd2)
            |-> (out_reg == $past(out_reg ^ bus_wdata)));

    a_r11_reserved_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && bus_addr == 2'd3)
            |-> ($stable(dir_reg) && $stable(out_reg)));

endmodule

bind gpio_ovr_port gpio_ovr_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .pull_dis    (pull_dis),
    .sleep_mode  (sleep_mode),
    .ovr_pu_en   (ovr_pu_en),
    .ovr_pu_val  (ovr_pu_val),
    .ovr_dir_en  (ovr_dir_en),
    .ovr_dir_val (ovr_dir_val),
    .ovr_pv_en   (ovr_pv_en),
    .ovr_pv_val  (ovr_pv_val),
    .ovr_die_en  (ovr_die_en),
    .pad_oe      (pad_oe),
    .pad_out     (pad_out),
    .pad_pu      (pad_pu),
    .periph_din  (periph_din),
    .dir_reg     (dir_reg),
    .out_reg     (out_reg),
    .pin_sync    (pin_sync)
);

// File: tb/gpio_ovr_port_tb.sv
module gpio_ovr_port_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       pull_dis = 1'b0;
    logic       sleep_mode = 1'b0;
    logic [7:0] ovr_pu_en = 8'h00, ovr_pu_val = 8'h00;
    logic [7:0] ovr_dir_en = 8'h00, ovr_dir_val = 8'h00;
    logic [7:0] ovr_pv_en = 8'h00, ovr_pv_val = 8'h00;
    logic [7:0] ovr_die_en = 8'h00, ovr_die_val = 8'h00;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_oe, pad_out, pad_pu, periph_din;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_ovr_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pull_dis(pull_dis),
        .sleep_mode(sleep_mode), .ovr_pu_en(ovr_pu_en), .ovr_pu_val(ovr_pu_val),
        .ovr_dir_en(ovr_dir_en), .ovr_dir_val(ovr_dir_val), .ovr_pv_en(ovr_pv_en),
        .ovr_pv_val(ovr_pv_val), .ovr_die_en(ovr_die_en), .ovr_die_val(ovr_die_val),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
        .periph_din(periph_din)
    );

    typedef struct packed {
        logic [7:0] dir, out;
        logic       pd, slp;
        logic [7:0] pu_en, pu_val, dir_en, dir_val, pv_en, pv_val, die_en, die_val, pad;
        logic [7:0] e_pu, e_oe, e_out, e_din;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{8'h0F, 8'h33, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hA5,
          8'h30, 8'h0F, 8'h33, 8'hA5},
        '{8'h0F, 8'h33, 1'b1, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hA5,
          8'h00, 8'h0F, 8'h33, 8'h00},
        '{8'hF0, 8'hCC, 1'b1, 1'b0, 8'hFF, 8'h5A, 8'h0F, 8'h0A, 8'hFF, 8'h96, 8'h00, 8'h00, 8'hFF,
          8'h5A, 8'hFA, 8'h96, 8'hFF},
        '{8'h00, 8'hFF, 1'b0, 1'b1, 8'h0F, 8'h00, 8'hF0, 8'h30, 8'h0F, 8'h0F, 8'hFF, 8'h0F, 8'hFF,
          8'hF0, 8'h30, 8'hFF, 8'h0F},
        '{8'hFF, 8'h00, 1'b0, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h3C, 8'h24, 8'hF0, 8'hC0, 8'hFF,
          8'h00, 8'hFF, 8'h24, 8'hC0},
        '{8'h55, 8'hAA, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h0F, 8'h00, 8'h5A,
          8'hAA, 8'h55, 8'hAA, 8'h50}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state seen at the ports
        chk("R1 oe", pad_oe, 8'h00);
        chk("R1 pu", pad_pu, 8'h00);
        rd_chk("R1 dir", 2'd0, 8'h00);
        rd_chk("R1 out", 2'd1, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            bus_wr(2'd0, VECS[i].dir);
            bus_wr(2'd1, VECS[i].out);
            pull_dis = VECS[i].pd;       sleep_mode = VECS[i].slp;
            ovr_pu_en = VECS[i].pu_en;   ovr_pu_val = VECS[i].pu_val;
            ovr_dir_en = VECS[i].dir_en; ovr_dir_val = VECS[i].dir_val;
            ovr_pv_en = VECS[i].pv_en;   ovr_pv_val = VECS[i].pv_val;
            ovr_die_en = VECS[i].die_en; ovr_die_val = VECS[i].die_val;
            pad_in = VECS[i].pad;
            repeat (3) @(negedge clk);
            #1;
            chk("R2/R3 pull-up", pad_pu, VECS[i].e_pu);
            chk("R4 output enable", pad_oe, VECS[i].e_oe);
            chk("R5 driven value", pad_out, VECS[i].e_out);
            chk("R6/R7 input tap", periph_din, VECS[i].e_din);
            rd_chk("R9 dir readback", 2'd0, VECS[i].dir);
            rd_chk("R9 out readback", 2'd1, VECS[i].out);
            rd_chk("R8 pin read settled", 2'd2, VECS[i].e_din);
        end

        // clear overrides, wake up
        pull_dis = 1'b0; sleep_mode = 1'b0;
        ovr_pu_en = 8'h00; ovr_dir_en = 8'h00; ovr_pv_en = 8'h00; ovr_die_en = 8'h00;
        pad_in = 8'h00;
        repeat (3) @(negedge clk);

        // R7 and R8: latency edge by edge
        pad_in = 8'h3C; bus_addr = 2'd2;
        #1;
        chk("R7 tap same cycle", periph_din, 8'h3C);
        chk("R8 zero edges", bus_rdata, 8'h00);
        @(negedge clk); #1;
        chk("R8 one edge", bus_rdata, 8'h00);
        @(negedge clk); #1;
        chk("R8 two edges", bus_rdata, 8'h3C);

        // R10: toggle through the pin-read address
        bus_wr(2'd1, 8'h33);
        bus_wr(2'd2, 8'hF0);
        rd_chk("R10 toggle ones", 2'd1, 8'hC3);
        bus_wr(2'd2, 8'h00);
        rd_chk("R10 zeros unchanged", 2'd1, 8'hC3);

        // R11: reserved address
        bus_wr(2'd0, 8'h81);
        bus_wr(2'd3, 8'hFF);
        rd_chk("R11 dir kept", 2'd0, 8'h81);
        rd_chk("R11 out kept", 2'd1, 8'hC3);
        rd_chk("R11 reads zero", 2'd3, 8'h00);

        // R2: pull-up on exactly where dir=0 and out=1; dir=81 out=C3 -> 42
        #1;
        chk("R2 pull-up pattern", pad_pu, 8'h42);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule